// File: doc/BRIEF.md
# Four-Channel PWM Configuration Register Block

This block is the control register file that sits in front of four PWM timer cores. It accepts 32-bit word reads and writes inside a 4 KiB address window. From the stored words it drives each channel's static configuration: prescale value, clock divider select, enable, output invert, run mode, period and compare value. Whenever a write alters what a channel should be running with, the block raises a one-cycle update strobe on that channel so its timer core reloads.

Three words are shared by all channels: a prescaler word, a clock-select word and a control word. The prescaler word carries only two prescalers, so channels 0 and 1 run from one and channels 2 and 3 from the other. Each channel also owns a period register, a compare register and a read-only data register. The data register shows the value its timer core presents on `ch_data`. Interrupt enable, interrupt status and per-channel watchdog words are plain storage and do not affect the channel outputs. The request side has no back-pressure: a request is taken on every cycle that `req_valid` is high. Each read returns its response exactly one cycle later. The response cannot be stalled, so a master must be ready for it.

Top module: `pwm_cfg_regs`

## Requirements
- R1: After reset every stored register is zero. All channel outputs and strobes are low, and reads of storage registers return zero.
- R2: A write to a channel's period register (offset 0x0C+12·n) or compare register (offset 0x10+12·n) drives that value on the channel's period or compare output from the next cycle. The value reads back zero-extended. Both outputs hold their value when no such write occurs.
- R3: A period or compare write with data above 65535 stores 65535. Data of 65535 or below is stored unchanged.
- R4: The prescaler word (offset 0x00) sets the prescale of channels 0 and 1 from bits 7:0 and that of channels 2 and 3 from bits 15:8. Its other bits read back as zero.
- R5: The clock-select word (offset 0x04) holds a 3-bit select for channel n at bit 4·n. Bits outside these fields read back as zero.
- R6: The control word (offset 0x08) holds a 4-bit field for channels 0, 1, 2 and 3 at bits 0, 8, 12 and 16. In each field, bit 0 is enable and bit 2 is invert. Bit 3 selects continuous toggle mode when 1 and one-shot mode when 0. Bits outside the fields read back as zero.
- R7: The data register of channel n (offset 0x14+12·n) reads the channel's `ch_data` slice. Writes to it change no output and raise no strobe.
- R8: The interrupt enable word (0x3C), the interrupt status word (0x40) and the watchdog words (0x44+4·n) read back the full 32 bits last written. Writing them changes no channel output and raises no strobe.
- R9: A read at an unmapped offset (0x54 and above) or a misaligned offset returns zero with `rsp_err` high for that single response. A write there changes nothing.
- R10: `ch_update[n]` pulses high for one cycle, in the cycle after a write, when that write hits channel n's period or compare register, or changes the value of a shared-word field that channel n uses. A shared-word write that leaves the field unchanged raises no strobe.
- R11: Every read request gives `rsp_valid` high in the next cycle with the read value on `rsp_rdata`. Otherwise `rsp_valid`, `rsp_rdata` and `rsp_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| ch_data | input | 128 | Per-channel data from the timer cores, channel n at bits 32n+31:32n |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| rsp_err | output | 1 | Read was at an unmapped or misaligned offset |
| ch_prescale | output | 32 | Prescale per channel, 8 bits each |
| ch_clksel | output | 12 | Divider select per channel, 3 bits each |
| ch_enable | output | 4 | Channel enable |
| ch_invert | output | 4 | Output invert |
| ch_toggle | output | 4 | 1 = continuous toggle mode, 0 = one-shot |
| ch_period | output | 64 | Period per channel, 16 bits each |
| ch_compare | output | 64 | Compare per channel, 16 bits each |
| ch_update | output | 4 | One-cycle reload strobe per channel |

## Verification
A behavioural model runs beside the block and its outputs are compared every cycle. Directed patterns come first. Shared-word writes repeat the same prescaler and selector values to separate change-only strobes from strobes raised on every write. Controls use field values whose enable, invert and mode bits all differ, so a field placed at the wrong bit position shows up. Period and compare writes probe values just below, at and above 65535 to expose truncation in place of saturation. A pseudo-random mix of reads and writes over mapped, unmapped and misaligned offsets then exercises decode and back-to-back accesses.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;

  typedef enum logic [3:0] {
    RK_NONE, RK_PRESC, RK_CLKSEL, RK_CTRL, RK_PERIOD,
    RK_COMPARE, RK_DATA, RK_INTEN, RK_INTSTAT, RK_WDOG
  } regkind_e;

  typedef struct packed {
    regkind_e   kind;
    logic [3:0] ch;
  } regsel_t;

  localparam int unsigned SEL_STRIDE = 4;
  localparam int unsigned CTL_W      = 4;

  // control field base: channel 0 at bit 0, later channels from bit 8 in steps of 4
  function automatic int unsigned ctrl_pos(input int unsigned c);
    return (c == 0) ? 0 : (4 + 4 * c);
  endfunction

endpackage

// File: rtl/pwmr_decode.sv
module pwmr_decode
  import pwmr_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned NCH = 4
) (
  input  logic [AW-1:0] addr,
  output regsel_t       sel
);
  localparam int unsigned CH_BASE  = 3;
  localparam int unsigned INT_BASE = CH_BASE + 3 * NCH;
  localparam int unsigned WD_BASE  = INT_BASE + 2;

  logic [31:0] w;

  always_comb begin
    w   = 32'(addr[AW-1:2]);
    sel = '{kind: RK_NONE, ch: 4'd0};
    if (addr[1:0] == 2'b00) begin
      if (w == 32'd0) sel.kind = RK_PRESC;
      if (w == 32'd1) sel.kind = RK_CLKSEL;
      if (w == 32'd2) sel.kind = RK_CTRL;
      if (w == 32'(INT_BASE))     sel.kind = RK_INTEN;
      if (w == 32'(INT_BASE + 1)) sel.kind = RK_INTSTAT;
      for (int c = 0; c < NCH; c++) begin
        if (w == 32'(CH_BASE + 3 * c)) begin sel.kind = RK_PERIOD;  sel.ch = 4'(c); end
        if (w == 32'(CH_BASE + 3 * c + 1)) begin sel.kind = RK_COMPARE; sel.ch = 4'(c); end
        if (w == 32'(CH_BASE + 3 * c + 2)) begin sel.kind = RK_DATA;    sel.ch = 4'(c); end
        if (w == 32'(WD_BASE + c)) begin sel.kind = RK_WDOG; sel.ch = 4'(c); end
      end
    end
  end
endmodule

// File: rtl/pwmr_shared.sv
module pwmr_shared
  import pwmr_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned PW  = 8,
  parameter int unsigned SW  = 3,
  parameter int unsigned DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  regkind_e          wr_kind,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     presc_word,
  output logic [DW-1:0]     clksel_word,
  output logic [DW-1:0]     ctrl_word,
  output logic [NCH*PW-1:0] prescale_o,
  output logic [NCH*SW-1:0] clksel_o,
  output logic [NCH-1:0]    enable_o,
  output logic [NCH-1:0]    invert_o,
  output logic [NCH-1:0]    toggle_o,
  output logic [NCH-1:0]    upd_o
);
  localparam int unsigned NPAIR = (NCH + 1) / 2;

  logic [PW-1:0]    pre_q [NPAIR];
  logic [SW-1:0]    cs_q  [NCH];
  logic [CTL_W-1:0] ct_q  [NCH];
  logic pre_we, cs_we, ct_we;

  assign pre_we = wr_en && (wr_kind == RK_PRESC);
  assign cs_we  = wr_en && (wr_kind == RK_CLKSEL);
  assign ct_we  = wr_en && (wr_kind == RK_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPAIR; p++) pre_q[p] <= '0;
      for (int c = 0; c < NCH; c++) begin
        cs_q[c] <= '0;
        ct_q[c] <= '0;
      end
      upd_o <= '0;
    end else begin
      upd_o <= '0;
      if (pre_we) begin
        for (int p = 0; p < NPAIR; p++) begin
          if (wr_data[p*PW +: PW] != pre_q[p]) begin
            pre_q[p]      <= wr_data[p*PW +: PW];
            upd_o[2*p]    <= 1'b1;
            if (2 * p + 1 < NCH) upd_o[2*p+1] <= 1'b1;
          end
        end
      end
      if (cs_we) begin
        for (int c = 0; c < NCH; c++) begin
          if (wr_data[SEL_STRIDE*c +: SW] != cs_q[c]) begin
            cs_q[c]  <= wr_data[SEL_STRIDE*c +: SW];
            upd_o[c] <= 1'b1;
          end
        end
      end
      if (ct_we) begin
        for (int c = 0; c < NCH; c++) begin
          if (wr_data[ctrl_pos(c) +: CTL_W] != ct_q[c]) begin
            ct_q[c]  <= wr_data[ctrl_pos(c) +: CTL_W];
            upd_o[c] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    presc_word  = '0;
    clksel_word = '0;
    ctrl_word   = '0;
    for (int p = 0; p < NPAIR; p++) presc_word[p*PW +: PW] = pre_q[p];
    for (int c = 0; c < NCH; c++) begin
      clksel_word[SEL_STRIDE*c +: SW] = cs_q[c];
      ctrl_word[ctrl_pos(c) +: CTL_W] = ct_q[c];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign prescale_o[c*PW +: PW] = pre_q[c/2];
    assign clksel_o[c*SW +: SW]   = cs_q[c];
    assign enable_o[c]            = ct_q[c][0];
    assign invert_o[c]            = ct_q[c][2];
    assign toggle_o[c]            = ct_q[c][3];
  end

  assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ct_we |=> $stable(ctrl_word));
  assert_presc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_we |=> $stable(prescale_o));
  assert_shared_strobe_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_o) |-> $past(wr_en));
endmodule

// File: rtl/pwmr_chan.sv
module pwmr_chan #(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          per_we,
  input  logic          cmp_we,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] period_o,
  output logic [CW-1:0] compare_o,
  output logic          upd_o
);
  logic [CW-1:0] clipped;

  // values that do not fit clamp to the all-ones maximum
  assign clipped = (|wr_data[DW-1:CW]) ? {CW{1'b1}} : wr_data[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_o  <= '0;
      compare_o <= '0;
      upd_o     <= 1'b0;
    end else begin
      upd_o <= per_we || cmp_we;
      if (per_we) period_o  <= clipped;
      if (cmp_we) compare_o <= clipped;
    end
  end

  assert_period_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !per_we |=> $stable(period_o));
  assert_compare_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_we |=> $stable(compare_o));
  assert_sat_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_we && (|wr_data[DW-1:CW])) |=> (&period_o));
  assert_chan_strobe_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(per_we || cmp_we));
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwmr_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned DW  = 32,
  parameter int unsigned NCH = 4,
  parameter int unsigned PW  = 8,
  parameter int unsigned SW  = 3,
  parameter int unsigned CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [NCH*DW-1:0] ch_data,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic [NCH*PW-1:0] ch_prescale,
  output logic [NCH*SW-1:0] ch_clksel,
  output logic [NCH-1:0]    ch_enable,
  output logic [NCH-1:0]    ch_invert,
  output logic [NCH-1:0]    ch_toggle,
  output logic [NCH*CW-1:0] ch_period,
  output logic [NCH*CW-1:0] ch_compare,
  output logic [NCH-1:0]    ch_update
);
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

  regsel_t       sel;
  logic          wr, rd;
  logic [DW-1:0] presc_word, clksel_word, ctrl_word;
  logic [NCH-1:0] sh_upd, cu_upd;
  logic [CW-1:0] per_arr [NCH];
  logic [CW-1:0] cmp_arr [NCH];
  logic [DW-1:0] inten_q, intst_q;
  logic [DW-1:0] wdog_q [NCH];
  logic [DW-1:0] rd_val;
  logic          rd_hit;
  logic [CHW-1:0] sel_ch;

  assign wr     = req_valid && req_write;
  assign rd     = req_valid && !req_write;
  assign sel_ch = sel.ch[CHW-1:0];

  pwmr_decode #(.AW(AW), .NCH(NCH)) u_dec (.addr(req_addr), .sel(sel));

  pwmr_shared #(.NCH(NCH), .PW(PW), .SW(SW), .DW(DW)) u_shared (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .wr_kind(sel.kind), .wr_data(req_wdata),
    .presc_word(presc_word), .clksel_word(clksel_word), .ctrl_word(ctrl_word),
    .prescale_o(ch_prescale), .clksel_o(ch_clksel), .enable_o(ch_enable),
    .invert_o(ch_invert), .toggle_o(ch_toggle), .upd_o(sh_upd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic per_we, cmp_we;
    assign per_we = wr && (sel.kind == RK_PERIOD)  && (sel.ch == 4'(c));
    assign cmp_we = wr && (sel.kind == RK_COMPARE) && (sel.ch == 4'(c));
    pwmr_chan #(.CW(CW), .DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n), .per_we(per_we), .cmp_we(cmp_we),
      .wr_data(req_wdata), .period_o(per_arr[c]), .compare_o(cmp_arr[c]),
      .upd_o(cu_upd[c])
    );
    assign ch_period[c*CW +: CW]  = per_arr[c];
    assign ch_compare[c*CW +: CW] = cmp_arr[c];
  end

  assign ch_update = sh_upd | cu_upd;

  // storage-only words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inten_q <= '0;
      intst_q <= '0;
      for (int c = 0; c < NCH; c++) wdog_q[c] <= '0;
    end else if (wr) begin
      if (sel.kind == RK_INTEN)   inten_q <= req_wdata;
      if (sel.kind == RK_INTSTAT) intst_q <= req_wdata;
      if (sel.kind == RK_WDOG)    wdog_q[sel_ch] <= req_wdata;
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    unique case (sel.kind)
      RK_PRESC:   rd_val = presc_word;
      RK_CLKSEL:  rd_val = clksel_word;
      RK_CTRL:    rd_val = ctrl_word;
      RK_PERIOD:  rd_val = DW'(per_arr[sel_ch]);
      RK_COMPARE: rd_val = DW'(cmp_arr[sel_ch]);
      RK_DATA:    rd_val = ch_data[sel_ch*DW +: DW];
      RK_INTEN:   rd_val = inten_q;
      RK_INTSTAT: rd_val = intst_q;
      RK_WDOG:    rd_val = wdog_q[sel_ch];
      default:    rd_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= (rd && rd_hit) ? rd_val : '0;
      rsp_err   <= rd && !rd_hit;
    end
  end

  assert_rsp_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_no_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> (!rsp_valid && !rsp_err && rsp_rdata == '0));
  assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
endmodule

// File: tb/tb_pwm_cfg_regs.sv
module tb_pwm_cfg_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [127:0] ch_data = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [31:0] ch_prescale;
  logic [11:0] ch_clksel;
  logic [3:0] ch_enable, ch_invert, ch_toggle, ch_update;
  logic [63:0] ch_period, ch_compare;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_cfg_regs dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ch_data(ch_data),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ch_prescale(ch_prescale), .ch_clksel(ch_clksel), .ch_enable(ch_enable),
    .ch_invert(ch_invert), .ch_toggle(ch_toggle), .ch_period(ch_period),
    .ch_compare(ch_compare), .ch_update(ch_update)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int unsigned m_per[4], m_cmp[4], m_pre[2], m_cs[4], m_ct[4], m_wd[4];
  int unsigned m_ie, m_is, m_rd;
  bit [3:0] m_upd;
  bit m_rv, m_re;
  int unsigned ctl_at[4] = '{0, 8, 12, 16};

  function automatic int unsigned sat(input int unsigned d);
    return (d > 65535) ? 65535 : d;
  endfunction

  function automatic int unsigned ref_read(input int unsigned a, output bit err);
    err = 0;
    if (a % 4 != 0) begin err = 1; return 0; end
    if (a == 0) return (m_pre[1] << 8) | m_pre[0];
    if (a == 4) begin
      int unsigned v = 0;
      for (int c = 0; c < 4; c++) v |= m_cs[c] << (4 * c);
      return v;
    end
    if (a == 8) begin
      int unsigned v = 0;
      for (int c = 0; c < 4; c++) v |= m_ct[c] << ctl_at[c];
      return v;
    end
    if (a == 'h3C) return m_ie;
    if (a == 'h40) return m_is;
    for (int c = 0; c < 4; c++) begin
      if (a == 'h0C + 12 * c) return m_per[c];
      if (a == 'h10 + 12 * c) return m_cmp[c];
      if (a == 'h14 + 12 * c) return ch_data[32*c +: 32];
      if (a == 'h44 + 4 * c) return m_wd[c];
    end
    err = 1;
    return 0;
  endfunction

  function automatic void ref_write(input int unsigned a, input int unsigned d);
    if (a % 4 != 0) return;
    if (a == 0) begin
      for (int p = 0; p < 2; p++)
        if (((d >> (8 * p)) & 255) != m_pre[p]) begin
          m_pre[p] = (d >> (8 * p)) & 255;
          m_upd[2*p] = 1; m_upd[2*p+1] = 1;
        end
    end else if (a == 4) begin
      for (int c = 0; c < 4; c++)
        if (((d >> (4 * c)) & 7) != m_cs[c]) begin
          m_cs[c] = (d >> (4 * c)) & 7; m_upd[c] = 1;
        end
    end else if (a == 8) begin
      for (int c = 0; c < 4; c++)
        if (((d >> ctl_at[c]) & 15) != m_ct[c]) begin
          m_ct[c] = (d >> ctl_at[c]) & 15; m_upd[c] = 1;
        end
    end else if (a == 'h3C) m_ie = d;
    else if (a == 'h40) m_is = d;
    else begin
      for (int c = 0; c < 4; c++) begin
        if (a == 'h0C + 12 * c) begin m_per[c] = sat(d); m_upd[c] = 1; end
        if (a == 'h10 + 12 * c) begin m_cmp[c] = sat(d); m_upd[c] = 1; end
        if (a == 'h44 + 4 * c) m_wd[c] = d;
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_per[c] = 0; m_cmp[c] = 0; m_cs[c] = 0; m_ct[c] = 0; m_wd[c] = 0;
      end
      m_pre[0] = 0; m_pre[1] = 0; m_ie = 0; m_is = 0;
      m_upd = 0; m_rv = 0; m_re = 0; m_rd = 0;
    end else begin
      m_upd = 0; m_rv = 0; m_re = 0; m_rd = 0;
      if (req_valid && !req_write) begin
        m_rv = 1;
        m_rd = ref_read(32'(req_addr), m_re);
      end
      if (req_valid && req_write) ref_write(32'(req_addr), req_wdata);
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [63:0] e_pre, e_cs, e_per, e_cmp;
      logic [3:0] e_en, e_inv, e_tog;
      e_pre = '0; e_cs = '0; e_per = '0; e_cmp = '0; e_en = '0; e_inv = '0; e_tog = '0;
      for (int c = 0; c < 4; c++) begin
        e_pre[8*c +: 8]   = 8'(m_pre[c/2]);
        e_cs[3*c +: 3]    = 3'(m_ct[c] >> 0 == 0 ? m_cs[c] : m_cs[c]);
        e_per[16*c +: 16] = 16'(m_per[c]);
        e_cmp[16*c +: 16] = 16'(m_cmp[c]);
        e_en[c]  = m_ct[c][0];
        e_inv[c] = m_ct[c][2];
        e_tog[c] = m_ct[c][3];
      end
      check("R4 prescale", 64'(ch_prescale), e_pre);
      check("R5 clksel", 64'(ch_clksel), e_cs);
      check("R6 enable", 64'(ch_enable), 64'(e_en));
      check("R6 invert", 64'(ch_invert), 64'(e_inv));
      check("R6 toggle", 64'(ch_toggle), 64'(e_tog));
      check("R2 period", ch_period, e_per);
      check("R2 compare", ch_compare, e_cmp);
      check("R10 update", 64'(ch_update), 64'(m_upd));
      check("R11 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      check("R11 rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
      check("R9 rsp_err", 64'(rsp_err), 64'(m_re));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int unsigned a, input int unsigned d);
    req_valid = 1; req_write = 1; req_addr = 12'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int unsigned a, input int unsigned exp, input bit exp_err, input string tag);
    req_valid = 1; req_write = 0; req_addr = 12'(a);
    @(negedge clk);
    req_valid = 0;
    check(tag, {rsp_err, rsp_valid, rsp_rdata}, {exp_err, 1'b1, exp});
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {ch_period, 32'(ch_prescale), 20'(ch_clksel), ch_enable, ch_invert, ch_toggle, ch_update},
          64'd0);
    rd('h08, 0, 0, "R1 ctrl word");
    rd('h3C, 0, 0, "R1 int enable");
    rd('h10, 0, 0, "R1 compare");

    // R2 period / compare
    wr('h0C, 1000);
    check("R2 ch0 period", 64'(ch_period[15:0]), 64'd1000);
    check("R10 ch0 strobe", 64'(ch_update), 64'b0001);
    wr('h34, 'h1234);
    check("R2 ch3 compare", 64'(ch_compare[63:48]), 64'h1234);
    check("R10 ch3 strobe", 64'(ch_update), 64'b1000);
    rd('h34, 'h1234, 0, "R2 readback");

    // R3 saturation
    wr('h18, 'h0001_0000);
    rd('h18, 65535, 0, "R3 over range");
    wr('h28, 'hFFFF_FFFF);
    rd('h28, 65535, 0, "R3 all ones");
    wr('h1C, 65535);
    rd('h1C, 65535, 0, "R3 at limit");
    wr('h1C, 65534);
    rd('h1C, 65534, 0, "R3 below limit");

    // R4 shared prescalers
    wr('h00, 'hFFFF_A53C);
    check("R4 prescale", 64'(ch_prescale), 64'hA5A5_3C3C);
    check("R10 presc strobe", 64'(ch_update), 64'b1111);
    rd('h00, 'hA53C, 0, "R4 readback");
    wr('h00, 'h0000_A577);
    check("R10 pair0 only", 64'(ch_update), 64'b0011);
    wr('h00, 'h0000_A577);
    check("R10 no change", 64'(ch_update), 64'b0000);

    // R5 clock selects
    wr('h04, 'hFFFF_CBA9);
    check("R5 clksel", 64'(ch_clksel), 64'({3'd4, 3'd3, 3'd2, 3'd1}));
    rd('h04, 'h0000_4321, 0, "R5 readback");

    // R6 control fields
    wr('h08, 'hFFF5_C9F1);
    check("R6 enable", 64'(ch_enable), 64'b1011);
    check("R6 invert", 64'(ch_invert), 64'b1100);
    check("R6 toggle", 64'(ch_toggle), 64'b0110);
    rd('h08, 'h0005_C901, 0, "R6 readback");

    // R7 data registers
    ch_data = 128'hDDDD_0003_CCCC_0002_BBBB_0001_AAAA_0000;
    rd('h14, 'hAAAA_0000, 0, "R7 ch0 data");
    wr('h38, 'h1111_2222);
    check("R7 no strobe", 64'(ch_update), 64'b0000);
    rd('h38, 'hDDDD_0003, 0, "R7 write ignored");

    // R8 storage-only words
    wr('h3C, 'hDEAD_BEEF);
    check("R8 no strobe", 64'(ch_update), 64'b0000);
    wr('h40, 'h0BAD_F00D);
    wr('h50, 'h1357_9BDF);
    rd('h3C, 'hDEAD_BEEF, 0, "R8 int enable");
    rd('h40, 'h0BAD_F00D, 0, "R8 int status");
    rd('h50, 'h1357_9BDF, 0, "R8 watchdog 3");
    check("R8 outputs kept", 64'(ch_enable), 64'b1011);

    // R9 unmapped / misaligned
    rd('h54, 0, 1, "R9 past map");
    rd('h0E, 0, 1, "R9 misaligned");
    rd('hFFC, 0, 1, "R9 top of window");
    wr('h60, 'hFFFF_FFFF);
    check("R9 write dropped", 64'(ch_update), 64'b0000);
    rd('h0C, 1000, 0, "R9 state kept");

    // R11 back-to-back reads
    req_valid = 1; req_write = 0; req_addr = 12'h00;
    @(negedge clk);
    req_addr = 12'h04;
    check("R11 first", 64'({rsp_valid, rsp_rdata}), 64'({1'b1, 32'h0000_A577}));
    @(negedge clk);
    req_valid = 0;
    check("R11 second", 64'({rsp_valid, rsp_rdata}), 64'({1'b1, 32'h0000_4321}));
    @(negedge clk);

    // mixed pseudo-random traffic, checked by the model
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      req_valid = lfsr[0] | lfsr[1];
      req_write = lfsr[2];
      req_addr  = lfsr[3] ? 12'({lfsr[8:4], 2'b00}) : 12'(lfsr[14:9]);
      req_wdata = lfsr[5] ? {lfsr[15:0], lfsr[31:16]} : {15'd0, lfsr[16:0]};
      @(negedge clk);
    end
    req_valid = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule